// File: doc/BRIEF.md
# Exception entry sequencer

This block performs the state changes a 32-bit RISC core makes when it enters an exception handler, a trap, an interrupt handler or a reset. The core's decode and memory-management logic raise one-cycle request pulses: a general exception with its code, a TLB exception with its code, a trap with an 8-bit immediate, an interrupt with the code chosen by the interrupt controller, a manual reset or a power-on reset. In the clock edge that samples a request, the block saves the interrupted program counter, the assembled status word and R15 into shadow registers. It writes the event-code register that belongs to the event, forms the handler address from the vector base, and raises the privilege, block and bank-select bits of the status word.

The block owns the status word, with the T, S, M and Q flags held as separate bits; the vector base; the floating-point control word's reset value; the shadow registers; and the two copies of general registers R0 to R7. Whenever the bank-select bit changes value, whether through an entry or through a status-word write from the core, the two copies trade places. The core reads and writes the active copy through a small register port and can also read the inactive copy. The redirect target and a one-cycle done pulse, tagged with the kind of event, tell the fetch stage where to go.

Top module: `exc_entry_seq`

## Requirements
- R1: After the reset input, and after a power-on reset request, the target PC is 0xA0000000, the next PC is 0xA0000002, the vector base is 0, the FP control word is 0x00040001, the status word is 0x700000F0, the exception-event code and all shadow, trap and interrupt-event registers are 0, and every banked general register reads 0.
- R2: On a general exception, TLB exception, trap or accepted interrupt, the saved PC takes `cur_pc`, the saved status takes the assembled status word as it stood before entry, and the saved stack register takes `cur_r15`.
- R3: After such an entry the status word equals the saved status with bit 30 (privileged), bit 29 (bank select) and bit 28 (event block) set. Whenever bit 29 changes value, the active and inactive copies of R0 to R7 exchange contents.
- R4: The target PC is the vector base plus 0x100 for a general exception or trap, plus 0x400 for a TLB exception, and plus 0x600 for an interrupt. The next PC is always the target plus 2.
- R5: A trap loads the trap register with the immediate shifted left by two and loads the exception-event code with 0x160.
- R6: A general exception raised while `in_slot` is high records `exc_slot_code` instead of `exc_code` and pulses `slot_clr` with the done pulse. Otherwise `slot_clr` stays low.
- R7: Exception, TLB, trap and reset codes go only to the exception-event register. Interrupt codes go only to the interrupt-event register, and the other register keeps its value.
- R8: A manual reset loads the exception-event code with 0x020 and the target PC with 0xA0000000. It sets bits 30, 29 and 28 and the interrupt-mask field (bits 7:4) of the status word and leaves the shadow registers untouched.
- R9: A status-word write keeps only the implemented bits (mask 0x700083F3). Flags T (bit 0), S (bit 1), Q (bit 8) and M (bit 9) are held separately and appear in the assembled word. A T write changes only bit 0.
- R10: Each request completes in the edge that samples it. `done` is high for exactly that one following cycle, `evt_kind` gives the event (1 power-on reset, 2 manual reset, 3 TLB, 4 general exception, 5 trap, 6 interrupt), and `done` stays low in a cycle after no request.
- R11: Coinciding requests resolve in the order power-on reset, manual reset, TLB exception, general exception, trap, interrupt. Only the winner takes effect.
- R12: An interrupt request is ignored while status bit 28 is set: no done pulse and no register change. Reset requests are never blocked.
- R13: `gpr_rdata` returns the active copy of the register selected by `gpr_idx`, and `bnk_rdata` returns the inactive copy. `gpr_we` writes the active copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_por | input | 1 | Power-on reset request |
| req_mrst | input | 1 | Manual reset request |
| req_tlb | input | 1 | TLB exception request |
| tlb_code | input | 12 | Code for the TLB exception |
| req_exc | input | 1 | General exception request |
| exc_code | input | 12 | Code for a general exception outside a delay slot |
| exc_slot_code | input | 12 | Code for a general exception inside a delay slot |
| in_slot | input | 1 | Faulting instruction is in a delay slot |
| req_trap | input | 1 | Trap request |
| trap_imm | input | 8 | Trap immediate |
| req_irq | input | 1 | Interrupt request |
| irq_code | input | 12 | Interrupt code from the controller |
| cur_pc | input | 32 | PC of the interrupted instruction |
| cur_r15 | input | 32 | Current R15 value |
| sr_we | input | 1 | Status-word write |
| sr_wdata | input | 32 | Status-word write data |
| t_we | input | 1 | T flag write |
| t_wdata | input | 1 | T flag write data |
| vbr_we | input | 1 | Vector base write |
| vbr_wdata | input | 32 | Vector base write data |
| gpr_we | input | 1 | Active R0..R7 write |
| gpr_idx | input | 3 | Register select for read and write |
| gpr_wdata | input | 32 | Register write data |
| gpr_rdata | output | 32 | Active copy of the selected register |
| bnk_rdata | output | 32 | Inactive copy of the selected register |
| done | output | 1 | One-cycle entry-complete pulse |
| evt_kind | output | 3 | Kind of event completed |
| slot_clr | output | 1 | Clear the core's delay-slot flag |
| pc_tgt | output | 32 | Redirect target PC |
| npc_tgt | output | 32 | Redirect next PC |
| sr_o | output | 32 | Assembled status word |
| vbr_o | output | 32 | Vector base |
| fpscr_o | output | 32 | FP control word |
| spc_o | output | 32 | Saved PC |
| ssr_o | output | 32 | Saved status word |
| sgr_o | output | 32 | Saved R15 |
| expevt_o | output | 12 | Exception-event code |
| intevt_o | output | 12 | Interrupt-event code |
| tra_o | output | 10 | Trap register |

## Verification
The hardest case to reach is a bank exchange that follows a long history. Each entry flips bank select only when the bit was clear beforehand, so the contents of both copies depend on every earlier status write and entry. The stimulus fills both copies with distinct values, then alternates status writes that clear bank select with entries that set it. The scoreboard's own bank model predicts which copy is active after each step, and the port reads check it. Blocked interrupts are reached by issuing one right after an entry, while bit 28 is still set from that entry. Priority is tested by raising several requests in the same cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    EV_NONE = 3'd0,
    EV_POR  = 3'd1,
    EV_MRST = 3'd2,
    EV_TLB  = 3'd3,
    EV_EXC  = 3'd4,
    EV_TRAP = 3'd5,
    EV_IRQ  = 3'd6
  } evt_kind_e;

  localparam int SRB_T  = 0;
  localparam int SRB_S  = 1;
  localparam int SRB_Q  = 8;
  localparam int SRB_M  = 9;
  localparam int SRB_BL = 28;
  localparam int SRB_RB = 29;
  localparam int SRB_MD = 30;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic      req_por,
  input  logic      req_mrst,
  input  logic      req_tlb,
  input  logic      req_exc,
  input  logic      req_trap,
  input  logic      req_irq,
  input  logic      blocked,
  output evt_kind_e kind
);
  always_comb begin
    if (req_por)                  kind = EV_POR;
    else if (req_mrst)            kind = EV_MRST;
    else if (req_tlb)             kind = EV_TLB;
    else if (req_exc)             kind = EV_EXC;
    else if (req_trap)            kind = EV_TRAP;
    else if (req_irq && !blocked) kind = EV_IRQ;
    else                          kind = EV_NONE;
  end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
  import exc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          CODE_W    = 12,
  parameter logic [31:0] OFS_GEN   = 32'h100,
  parameter logic [31:0] OFS_TLB   = 32'h400,
  parameter logic [31:0] OFS_IRQ   = 32'h600,
  parameter logic [11:0] TRAP_CODE = 12'h160
) (
  input  evt_kind_e           kind,
  input  logic [XLEN-1:0]     vbr,
  input  logic [CODE_W-1:0]   tlb_code,
  input  logic [CODE_W-1:0]   exc_code,
  input  logic [CODE_W-1:0]   exc_slot_code,
  input  logic                in_slot,
  output logic [XLEN-1:0]     vec_pc,
  output logic [CODE_W-1:0]   evt_code
);
  always_comb begin
    vec_pc   = vbr + XLEN'(OFS_GEN);
    evt_code = in_slot ? exc_slot_code : exc_code;
    case (kind)
      EV_TLB: begin
        vec_pc   = vbr + XLEN'(OFS_TLB);
        evt_code = tlb_code;
      end
      EV_TRAP: evt_code = CODE_W'(TRAP_CODE);
      EV_IRQ:  vec_pc   = vbr + XLEN'(OFS_IRQ);
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_bank_file.sv
module exc_bank_file #(
  parameter int NREG = 8,
  parameter int W    = 32,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          swap,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  act_rdata,
  output logic [W-1:0]  bnk_rdata
);
  logic [W-1:0] act_q [NREG];
  logic [W-1:0] bnk_q [NREG];

  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_slot
      logic [W-1:0] act_n, bnk_n;
      always_comb begin
        act_n = act_q[g];
        bnk_n = bnk_q[g];
        if (clr) begin
          act_n = '0;
          bnk_n = '0;
        end else if (swap) begin
          act_n = bnk_q[g];
          bnk_n = act_q[g];
        end else if (we && idx == IW'(g)) begin
          act_n = wdata;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          act_q[g] <= '0;
          bnk_q[g] <= '0;
        end else if (clr || swap || we) begin
          act_q[g] <= act_n;
          bnk_q[g] <= bnk_n;
        end
      end
      // R3
      swap_exchange_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !clr) |=> (act_q[g] == $past(bnk_q[g]) && bnk_q[g] == $past(act_q[g])));
    end
  endgenerate

  assign act_rdata = act_q[idx];
  assign bnk_rdata = bnk_q[idx];
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int          XLEN      = 32,
  parameter int          CODE_W    = 12,
  parameter int          IMM_W     = 8,
  parameter int          NBANK     = 8,
  parameter logic [31:0] RESET_PC  = 32'hA000_0000,
  parameter logic [31:0] SR_POR    = 32'h7000_00F0,
  parameter logic [31:0] FPSCR_POR = 32'h0004_0001,
  parameter logic [31:0] SR_IMPL   = 32'h7000_83F3,
  parameter logic [11:0] MRST_CODE = 12'h020,
  parameter logic [11:0] TRAP_CODE = 12'h160,
  localparam int         IW        = $clog2(NBANK),
  localparam int         TRA_W     = IMM_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_por,
  input  logic              req_mrst,
  input  logic              req_tlb,
  input  logic [CODE_W-1:0] tlb_code,
  input  logic              req_exc,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [CODE_W-1:0] exc_slot_code,
  input  logic              in_slot,
  input  logic              req_trap,
  input  logic [IMM_W-1:0]  trap_imm,
  input  logic              req_irq,
  input  logic [CODE_W-1:0] irq_code,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_r15,
  input  logic              sr_we,
  input  logic [XLEN-1:0]   sr_wdata,
  input  logic              t_we,
  input  logic              t_wdata,
  input  logic              vbr_we,
  input  logic [XLEN-1:0]   vbr_wdata,
  input  logic              gpr_we,
  input  logic [IW-1:0]     gpr_idx,
  input  logic [XLEN-1:0]   gpr_wdata,
  output logic [XLEN-1:0]   gpr_rdata,
  output logic [XLEN-1:0]   bnk_rdata,
  output logic              done,
  output logic [2:0]        evt_kind,
  output logic              slot_clr,
  output logic [XLEN-1:0]   pc_tgt,
  output logic [XLEN-1:0]   npc_tgt,
  output logic [XLEN-1:0]   sr_o,
  output logic [XLEN-1:0]   vbr_o,
  output logic [XLEN-1:0]   fpscr_o,
  output logic [XLEN-1:0]   spc_o,
  output logic [XLEN-1:0]   ssr_o,
  output logic [XLEN-1:0]   sgr_o,
  output logic [CODE_W-1:0] expevt_o,
  output logic [CODE_W-1:0] intevt_o,
  output logic [TRA_W-1:0]  tra_o
);
  localparam logic [XLEN-1:0] FLAG_MSK  = XLEN'((1 << SRB_T) | (1 << SRB_S) | (1 << SRB_Q) | (1 << SRB_M));
  localparam logic [XLEN-1:0] ENTRY_SET = XLEN'((1 << SRB_MD) | (1 << SRB_RB) | (1 << SRB_BL));
  localparam logic [XLEN-1:0] IMASK_SET = XLEN'(32'h0000_00F0);

  // state registers
  logic [XLEN-1:0]   pc_q, sr_q, vbr_q, fpscr_q, spc_q, ssr_q, sgr_q;
  logic [CODE_W-1:0] expevt_q, intevt_q;
  logic [TRA_W-1:0]  tra_q;
  logic              t_q, s_q, m_q, q_q, done_q, slot_clr_q;
  evt_kind_e         kind_q;

  // next-state values
  logic [XLEN-1:0]   pc_n, vbr_n, fpscr_n, spc_n, ssr_n, sgr_n, srf_n;
  logic [CODE_W-1:0] expevt_n, intevt_n;
  logic [TRA_W-1:0]  tra_n;
  logic              upd_en, bank_swap, bank_clr;

  logic [XLEN-1:0]   sr_asm, vec_pc;
  logic [CODE_W-1:0] evt_code;
  evt_kind_e         kind;

  assign sr_asm = (sr_q & ~FLAG_MSK)
                | (XLEN'(t_q) << SRB_T) | (XLEN'(s_q) << SRB_S)
                | (XLEN'(q_q) << SRB_Q) | (XLEN'(m_q) << SRB_M);

  exc_arbiter u_arb (
    .req_por (req_por), .req_mrst(req_mrst), .req_tlb(req_tlb),
    .req_exc (req_exc), .req_trap(req_trap), .req_irq(req_irq),
    .blocked (sr_asm[SRB_BL]), .kind(kind)
  );

  exc_vector #(.XLEN(XLEN), .CODE_W(CODE_W), .TRAP_CODE(TRAP_CODE)) u_vec (
    .kind(kind), .vbr(vbr_q), .tlb_code(tlb_code), .exc_code(exc_code),
    .exc_slot_code(exc_slot_code), .in_slot(in_slot),
    .vec_pc(vec_pc), .evt_code(evt_code)
  );

  always_comb begin
    pc_n     = pc_q;
    vbr_n    = vbr_q;
    fpscr_n  = fpscr_q;
    spc_n    = spc_q;
    ssr_n    = ssr_q;
    sgr_n    = sgr_q;
    expevt_n = expevt_q;
    intevt_n = intevt_q;
    tra_n    = tra_q;
    srf_n    = sr_asm;
    bank_clr = 1'b0;
    case (kind)
      EV_POR: begin
        pc_n     = XLEN'(RESET_PC);
        vbr_n    = '0;
        fpscr_n  = XLEN'(FPSCR_POR);
        spc_n    = '0;
        ssr_n    = '0;
        sgr_n    = '0;
        expevt_n = '0;
        intevt_n = '0;
        tra_n    = '0;
        srf_n    = XLEN'(SR_POR);
        bank_clr = 1'b1;
      end
      EV_MRST: begin
        pc_n     = XLEN'(RESET_PC);
        expevt_n = CODE_W'(MRST_CODE);
        srf_n    = sr_asm | ENTRY_SET | IMASK_SET;
      end
      EV_TLB, EV_EXC, EV_TRAP, EV_IRQ: begin
        spc_n = cur_pc;
        ssr_n = sr_asm;
        sgr_n = cur_r15;
        pc_n  = vec_pc;
        srf_n = sr_asm | ENTRY_SET;
        if (kind == EV_IRQ) intevt_n = irq_code;
        else                expevt_n = evt_code;
        if (kind == EV_TRAP) tra_n = {trap_imm, 2'b00};
      end
      default: begin
        if (sr_we)     srf_n = sr_wdata;
        else if (t_we) srf_n[SRB_T] = t_wdata;
        if (vbr_we)    vbr_n = vbr_wdata;
      end
    endcase
    srf_n     = srf_n & XLEN'(SR_IMPL);
    bank_swap = (kind != EV_POR) && (srf_n[SRB_RB] != sr_asm[SRB_RB]);
    upd_en    = (kind != EV_NONE) || sr_we || t_we || vbr_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= XLEN'(RESET_PC);
      sr_q     <= XLEN'(SR_POR) & ~FLAG_MSK;
      t_q      <= SR_POR[SRB_T];
      s_q      <= SR_POR[SRB_S];
      q_q      <= SR_POR[SRB_Q];
      m_q      <= SR_POR[SRB_M];
      vbr_q    <= '0;
      fpscr_q  <= XLEN'(FPSCR_POR);
      spc_q    <= '0;
      ssr_q    <= '0;
      sgr_q    <= '0;
      expevt_q <= '0;
      intevt_q <= '0;
      tra_q    <= '0;
    end else if (upd_en) begin
      pc_q     <= pc_n;
      sr_q     <= srf_n & ~FLAG_MSK;
      t_q      <= srf_n[SRB_T];
      s_q      <= srf_n[SRB_S];
      q_q      <= srf_n[SRB_Q];
      m_q      <= srf_n[SRB_M];
      vbr_q    <= vbr_n;
      fpscr_q  <= fpscr_n;
      spc_q    <= spc_n;
      ssr_q    <= ssr_n;
      sgr_q    <= sgr_n;
      expevt_q <= expevt_n;
      intevt_q <= intevt_n;
      tra_q    <= tra_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q     <= 1'b0;
      kind_q     <= EV_NONE;
      slot_clr_q <= 1'b0;
    end else begin
      done_q     <= (kind != EV_NONE);
      kind_q     <= kind;
      slot_clr_q <= (kind == EV_EXC) && in_slot;
    end
  end

  exc_bank_file #(.NREG(NBANK), .W(XLEN)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(bank_clr), .swap(bank_swap),
    .we(gpr_we && (kind == EV_NONE)), .idx(gpr_idx), .wdata(gpr_wdata),
    .act_rdata(gpr_rdata), .bnk_rdata(bnk_rdata)
  );

  assign done     = done_q;
  assign evt_kind = kind_q;
  assign slot_clr = slot_clr_q;
  assign pc_tgt   = pc_q;
  assign npc_tgt  = pc_q + XLEN'(2);
  assign sr_o     = sr_asm;
  assign vbr_o    = vbr_q;
  assign fpscr_o  = fpscr_q;
  assign spc_o    = spc_q;
  assign ssr_o    = ssr_q;
  assign sgr_o    = sgr_q;
  assign expevt_o = expevt_q;
  assign intevt_o = intevt_q;
  assign tra_o    = tra_q;

  // R10
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_por || req_mrst || req_tlb || req_exc || req_trap || req_irq) |=> !done);
  // R3
  entry_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && evt_kind != EV_POR) |-> (sr_o[SRB_MD] && sr_o[SRB_RB] && sr_o[SRB_BL]));
  // R12
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_irq && sr_o[SRB_BL] && !req_por && !req_mrst && !req_tlb && !req_exc && !req_trap)
    |=> (!done && $stable(intevt_o)));
  // R7
  irq_keeps_expevt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && evt_kind == EV_IRQ) |-> $stable(expevt_o));
  // R8
  mrst_imask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && evt_kind == EV_MRST) |-> (sr_o[7:4] == 4'hF && $stable(spc_o)));
  // R2
  exc_saves_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_exc && !req_por && !req_mrst && !req_tlb) |=> (spc_o == $past(cur_pc) && sgr_o == $past(cur_r15)));
endmodule

// File: tb/tb_exc_entry_seq.sv
module tb_exc_entry_seq;
  localparam logic [31:0] MASK = 32'h7000_83F3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_por = 0, req_mrst = 0, req_tlb = 0, req_exc = 0, req_trap = 0, req_irq = 0;
  logic [11:0] tlb_code = 0, exc_code = 0, exc_slot_code = 0, irq_code = 0;
  logic        in_slot = 0;
  logic [7:0]  trap_imm = 0;
  logic [31:0] cur_pc = 0, cur_r15 = 0;
  logic        sr_we = 0, t_we = 0, t_wdata = 0, vbr_we = 0, gpr_we = 0;
  logic [31:0] sr_wdata = 0, vbr_wdata = 0, gpr_wdata = 0;
  logic [2:0]  gpr_idx = 0;
  logic [31:0] gpr_rdata, bnk_rdata, pc_tgt, npc_tgt, sr_o, vbr_o, fpscr_o, spc_o, ssr_o, sgr_o;
  logic        done, slot_clr;
  logic [2:0]  evt_kind;
  logic [11:0] expevt_o, intevt_o;
  logic [9:0]  tra_o;

  exc_entry_seq dut (.*);

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // reference model
  logic [31:0] m_sr, m_vbr, m_pc, m_spc, m_ssr, m_sgr;
  logic [11:0] m_expevt, m_intevt;
  logic [9:0]  m_tra;
  logic [31:0] m_act [8];
  logic [31:0] m_bnk [8];

  task automatic model_por();
    m_sr = 32'h7000_00F0; m_vbr = 0; m_pc = 32'hA000_0000;
    m_spc = 0; m_ssr = 0; m_sgr = 0; m_expevt = 0; m_intevt = 0; m_tra = 0;
    for (int i = 0; i < 8; i++) begin m_act[i] = 0; m_bnk[i] = 0; end
  endtask

  task automatic set_sr(input logic [31:0] v);
    logic [31:0] nv;
    nv = v & MASK;
    if (nv[29] != m_sr[29])
      for (int i = 0; i < 8; i++) begin
        logic [31:0] t;
        t = m_act[i]; m_act[i] = m_bnk[i]; m_bnk[i] = t;
      end
    m_sr = nv;
  endtask

  typedef struct {
    string       tag;
    logic [2:0]  kind;
    logic        slot;
    logic [31:0] pc, sr, vbr, spc, ssr, sgr;
    logic [11:0] expevt, intevt;
    logic [9:0]  tra;
  } item_t;
  item_t sb[$];

  // driver: raise a set of requests for one cycle, push the predicted result
  task automatic fire(input bit por, mrst, tlb, exc, trap, irq, input string tag);
    item_t it;
    logic [2:0] k;
    @(negedge clk);
    req_por = por; req_mrst = mrst; req_tlb = tlb; req_exc = exc; req_trap = trap; req_irq = irq;
    k = 0;
    if (por) begin k = 1; model_por(); end
    else if (mrst) begin
      k = 2; m_expevt = 12'h020; m_pc = 32'hA000_0000;
      set_sr(m_sr | 32'h7000_00F0);
    end else if (tlb || exc || trap || (irq && !m_sr[28])) begin
      k = tlb ? 3'd3 : exc ? 3'd4 : trap ? 3'd5 : 3'd6;
      m_spc = cur_pc; m_ssr = m_sr; m_sgr = cur_r15;
      case (k)
        3'd3: begin m_pc = m_vbr + 32'h400; m_expevt = tlb_code; end
        3'd4: begin m_pc = m_vbr + 32'h100; m_expevt = in_slot ? exc_slot_code : exc_code; end
        3'd5: begin m_pc = m_vbr + 32'h100; m_expevt = 12'h160; m_tra = {trap_imm, 2'b00}; end
        default: begin m_pc = m_vbr + 32'h600; m_intevt = irq_code; end
      endcase
      set_sr(m_ssr | 32'h7000_0000);
    end
    if (k != 0) begin
      it.tag = tag; it.kind = k; it.slot = (k == 4) && in_slot;
      it.pc = m_pc; it.sr = m_sr; it.vbr = m_vbr; it.spc = m_spc; it.ssr = m_ssr;
      it.sgr = m_sgr; it.expevt = m_expevt; it.intevt = m_intevt; it.tra = m_tra;
      sb.push_back(it);
    end
    @(negedge clk);
    req_por = 0; req_mrst = 0; req_tlb = 0; req_exc = 0; req_trap = 0; req_irq = 0;
  endtask

  // monitor: compare each done pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10: actual done=1 expected no entry");
      end else begin
        item_t e;
        e = sb.pop_front();
        chk({e.tag, " R10 kind"}, 32'(evt_kind), 32'(e.kind));
        chk({e.tag, " R4 pc"}, pc_tgt, e.pc);
        chk({e.tag, " R4 npc"}, npc_tgt, e.pc + 2);
        chk({e.tag, " R3 sr"}, sr_o, e.sr);
        chk({e.tag, " R2 spc"}, spc_o, e.spc);
        chk({e.tag, " R2 ssr"}, ssr_o, e.ssr);
        chk({e.tag, " R2 sgr"}, sgr_o, e.sgr);
        chk({e.tag, " R7 expevt"}, 32'(expevt_o), 32'(e.expevt));
        chk({e.tag, " R7 intevt"}, 32'(intevt_o), 32'(e.intevt));
        chk({e.tag, " R5 tra"}, 32'(tra_o), 32'(e.tra));
        chk({e.tag, " R6 slot_clr"}, 32'(slot_clr), 32'(e.slot));
        chk({e.tag, " vbr"}, vbr_o, e.vbr);
      end
    end
  end

  task automatic wr_sr(input logic [31:0] v);
    @(negedge clk); sr_we = 1; sr_wdata = v; set_sr(v);
    @(negedge clk); sr_we = 0;
  endtask

  task automatic wr_gpr(input int i, input logic [31:0] v);
    @(negedge clk); gpr_we = 1; gpr_idx = 3'(i); gpr_wdata = v; m_act[i] = v;
    @(negedge clk); gpr_we = 0;
  endtask

  task automatic chk_bank(input string tag);
    for (int i = 0; i < 8; i++) begin
      gpr_idx = 3'(i); #1;
      chk({tag, " R13 active"}, gpr_rdata, m_act[i]);
      chk({tag, " R13 inactive"}, bnk_rdata, m_bnk[i]);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_por();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pc", pc_tgt, 32'hA000_0000);
    chk("R1 npc", npc_tgt, 32'hA000_0002);
    chk("R1 vbr", vbr_o, 0);
    chk("R1 fpscr", fpscr_o, 32'h0004_0001);
    chk("R1 sr", sr_o, 32'h7000_00F0);
    chk("R1 expevt", 32'(expevt_o), 0);
    chk("R10 done idle", 32'(done), 0);

    @(negedge clk); vbr_we = 1; vbr_wdata = 32'h8C00_0000; m_vbr = vbr_wdata;
    @(negedge clk); vbr_we = 0;
    for (int i = 0; i < 8; i++) wr_gpr(i, 32'h100 + i);
    wr_sr(32'h0000_00F0);                    // bank select 1 -> 0, R3 swap
    for (int i = 0; i < 8; i++) wr_gpr(i, 32'h200 + i);
    chk_bank("R3 after sr write");

    // R9 masking and flags
    wr_sr(32'hFFFF_FFFF);
    chk("R9 mask", sr_o, 32'h7000_83F3);
    wr_sr(32'h0000_0303);
    chk("R9 flags", sr_o, 32'h0000_0303);
    @(negedge clk); t_we = 1; t_wdata = 0; m_sr[0] = 0;
    @(negedge clk); t_we = 0;
    chk("R9 t write", sr_o, 32'h0000_0302);

    // general exception
    cur_pc = 32'h8C00_1000; cur_r15 = 32'hDEAD_0015; exc_code = 12'h0E0; exc_slot_code = 12'h1A0;
    fire(0, 0, 0, 1, 0, 0, "exc");
    chk_bank("R3 after entry");
    // R12 interrupt while blocked
    irq_code = 12'h320;
    fire(0, 0, 0, 0, 0, 1, "irq blocked");
    chk("R12 no done", 32'(done), 0);
    chk("R12 intevt kept", 32'(intevt_o), 0);
    chk("R10 single pulse", 32'(done), 0);

    wr_sr(32'h0000_00F0);
    cur_pc = 32'h8C00_2000; cur_r15 = 32'h0000_1111;
    fire(0, 0, 0, 0, 0, 1, "irq");
    wr_sr(0);
    tlb_code = 12'h040; cur_pc = 32'h8C00_3000;
    fire(0, 0, 1, 0, 0, 0, "tlb");
    wr_sr(0);
    trap_imm = 8'hC3; cur_pc = 32'h8C00_4000;
    fire(0, 0, 0, 0, 1, 0, "trap");
    wr_sr(0);
    in_slot = 1; exc_code = 12'h180; cur_pc = 32'h8C00_5002;
    fire(0, 0, 0, 1, 0, 0, "slot exc");
    in_slot = 0;
    chk_bank("R3 bank history");

    // R11 priority
    wr_sr(0);
    tlb_code = 12'h0A0; trap_imm = 8'h11; cur_pc = 32'h8C00_6000;
    fire(0, 0, 1, 1, 1, 1, "R11 tlb wins");
    wr_sr(0);
    exc_code = 12'h1E0;
    fire(0, 0, 0, 1, 1, 1, "R11 exc wins");
    wr_sr(0);
    trap_imm = 8'h22;
    fire(0, 0, 0, 0, 1, 1, "R11 trap wins");
    // R8 manual reset while blocked, with a competing exception
    fire(0, 1, 0, 1, 0, 0, "R8 mrst");
    // R1 power-on reset request beats manual reset
    fire(1, 1, 0, 0, 0, 0, "R1 por");
    @(negedge clk);
    chk("R1 fpscr after por", fpscr_o, 32'h0004_0001);
    chk_bank("R1 bank cleared");
    repeat (2) @(negedge clk);
    chk("R10 queue drained", 32'(sb.size()), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule